// File: doc/BRIEF.md
# Periodic Down-Counting Interrupt Timer

This block is a programmable down-counter that produces a periodic interrupt for a host processor. A prescaler divides the system clock into a fixed time base (one step per 100 µs at the default setting), and on each step the counter moves down by one. The host sets a preload value, turns the timer on and off, and turns its interrupt on and off. It can read the live count, and it can read and clear a sticky status flag.

When the timer is switched on, counting starts from the preload value. Each time the count passes zero it starts again from the all-ones value rather than from the preload. If the interrupt is enabled, that wrap also sets the status flag. When the timer is switched off, the count returns to all ones. If the host writes a new preload while the timer runs, the countdown restarts from that value at once. The host bus decoding sits outside this block: the host side arrives as simple write strobes with their data.

Top module: `gptTimer`

## Requirements
- R1: After reset the count is all ones (FFFFh), the status flag is 0 and the IRQ output is 0.
- R2: A configuration write that changes the enable from 0 to 1 loads the stored preload into the count on the next cycle. If a preload write arrives in the same cycle, its new value is loaded instead. The first decrement follows TICK_DIV cycles later.
- R3: While the timer is enabled, the count drops by exactly one every TICK_DIV system clocks.
- R4: A configuration write with the enable at 0 sets the count to FFFFh on the next cycle, and the count stays there while the timer is disabled.
- R5: A preload write while the timer is disabled leaves the count unchanged. The value is stored and used by the next enable.
- R6: A preload write while the timer is enabled puts the new value in the count on the next cycle and restarts the prescaler, so the next decrement comes TICK_DIV cycles after the write.
- R7: A step taken at count 0000h wraps the count to FFFFh, not to the preload, and counting continues from there.
- R8: A wrap sets the status flag only if the interrupt enable is 1. With the interrupt enable at 0 the flag stays 0.
- R9: The status flag is sticky. A status write with data 1 clears it, and a status write with data 0 leaves it unchanged.
- R10: If a clearing status write and a flag-setting wrap happen in the same cycle, the flag is 1 afterwards.
- R11: The IRQ output is registered: in each cycle it equals the AND of the status flag and the interrupt enable as they were in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Strobe that writes the configuration bits |
| cfgEnable | input | 1 | Timer enable value to write |
| cfgIrqEn | input | 1 | Interrupt enable value to write |
| loadWrEn | input | 1 | Strobe that writes the preload value |
| loadValue | input | CNT_W | Preload value |
| stsWrEn | input | 1 | Strobe that writes the status flag |
| stsWrData | input | 1 | Status write data; 1 clears the flag |
| count | output | CNT_W | Current count |
| status | output | 1 | Sticky status flag |
| irq | output | 1 | Registered interrupt request |

## Verification
Several properties are checked on every cycle. The flag stays set unless a clearing write arrives, and it cannot set while the interrupt is masked. The IRQ output lags the flag AND the interrupt enable by one cycle. A disabling write drives the count to FFFFh, and the count never moves by more than one step unless there is a host write or a wrap. A clearing write that collides with a wrap leaves the flag set. Only the bench scenarios can show the exact cycle spacing of the prescaler. The same goes for the value loaded on enable and the restart on a running preload write, for where the count lands after a wrap, and for the reset values.

// File: rtl/gptPkg.sv
package gptPkg;
  // Strobes from control to datapath; priority loadMax > loadPre > dec.
  typedef struct packed {
    logic loadMax;
    logic loadPre;
    logic dec;
  } cntStrobeT;
endpackage

// File: rtl/gptDatapath.sv
module gptDatapath import gptPkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobeT        strb,
  input  logic             loadWrEn,
  input  logic [CNT_W-1:0] loadValue,
  output logic [CNT_W-1:0] count,
  output logic             cntZero
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] preloadReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preloadReg <= '0;
    else if (loadWrEn) preloadReg <= loadValue;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= CNT_MAX;
    else if (strb.loadMax) count <= CNT_MAX;
    else if (strb.loadPre) count <= loadWrEn ? loadValue : preloadReg;
    else if (strb.dec) count <= count - 1'b1;
  end

  assign cntZero = (count == '0);
endmodule

// File: rtl/gptCtrl.sv
module gptCtrl import gptPkg::*; #(
  parameter int TICK_DIV = 12500
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgWrEn,
  input  logic      cfgEnable,
  input  logic      cfgIrqEn,
  input  logic      loadWrEn,
  input  logic      stsWrEn,
  input  logic      stsWrData,
  input  logic      cntZero,
  output cntStrobeT strb,
  output logic      enState,
  output logic      irqEnState,
  output logic      wrapEvt,
  output logic      status,
  output logic      irq
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRESC_LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] presc;
  logic enNext, enRise, enFall, tick, restart;

  assign enNext  = cfgWrEn ? cfgEnable : enState;
  assign enRise  = enNext & ~enState;
  assign enFall  = enState & ~enNext;
  assign restart = enRise | (enState & enNext & loadWrEn);
  assign tick    = enState && (presc == PRESC_LAST);

  always_comb begin
    strb.loadMax = enFall | (tick & cntZero & ~restart);
    strb.loadPre = restart & ~enFall;
    strb.dec     = tick & ~cntZero & ~restart & ~enFall;
    wrapEvt      = tick & cntZero & ~restart & ~enFall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enState    <= 1'b0;
      irqEnState <= 1'b0;
    end else if (cfgWrEn) begin
      enState    <= cfgEnable;
      irqEnState <= cfgIrqEn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) presc <= '0;
    else if (!enNext || restart || tick) presc <= '0;
    else presc <= presc + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status <= 1'b0;
      irq    <= 1'b0;
    end else begin
      status <= (wrapEvt & irqEnState) | (status & ~(stsWrEn & stsWrData));
      irq    <= status & irqEnState;
    end
  end
endmodule

// File: rtl/gptTimer.sv
module gptTimer import gptPkg::*; #(
  parameter int CNT_W    = 16,
  parameter int TICK_DIV = 12500
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic             cfgEnable,
  input  logic             cfgIrqEn,
  input  logic             loadWrEn,
  input  logic [CNT_W-1:0] loadValue,
  input  logic             stsWrEn,
  input  logic             stsWrData,
  output logic [CNT_W-1:0] count,
  output logic             status,
  output logic             irq
);
  cntStrobeT strb;
  logic cntZero, enState, irqEnState, wrapEvt;

  gptCtrl #(.TICK_DIV(TICK_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgEnable(cfgEnable),
    .cfgIrqEn(cfgIrqEn), .loadWrEn(loadWrEn), .stsWrEn(stsWrEn),
    .stsWrData(stsWrData), .cntZero(cntZero), .strb(strb),
    .enState(enState), .irqEnState(irqEnState), .wrapEvt(wrapEvt),
    .status(status), .irq(irq)
  );

  gptDatapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .loadWrEn(loadWrEn),
    .loadValue(loadValue), .count(count), .cntZero(cntZero)
  );
endmodule

// File: rtl/gptTimerChk.sv
module gptTimerChk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWrEn,
  input logic             cfgEnable,
  input logic             loadWrEn,
  input logic             stsWrEn,
  input logic             stsWrData,
  input logic [CNT_W-1:0] count,
  input logic             status,
  input logic             irq,
  input logic             enState,
  input logic             irqEnState,
  input logic             wrapEvt
);
  a_r4_disable_max: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !cfgEnable) |=> (count == '1));

  a_r4_hold_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!enState && !(cfgWrEn && cfgEnable)) |=> (count == '1));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (enState && !cfgWrEn && !loadWrEn) |=>
      (count == $past(count) || count == CNT_W'($past(count) - 1'b1) || count == '1));

  a_r8_masked_no_set: assert property (@(posedge clk) disable iff (!rstN)
    (!status && !irqEnState) |=> !status);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (status && !(stsWrEn && stsWrData)) |=> status);

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (wrapEvt && irqEnState && stsWrEn && stsWrData) |=> status);

  a_r11_irq_lag: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irq == ($past(status) && $past(irqEnState))));
endmodule

bind gptTimer gptTimerChk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgEnable(cfgEnable),
  .loadWrEn(loadWrEn), .stsWrEn(stsWrEn), .stsWrData(stsWrData),
  .count(count), .status(status), .irq(irq), .enState(enState),
  .irqEnState(irqEnState), .wrapEvt(wrapEvt)
);

// File: tb/tb_gptTimer.sv
module tb_gptTimer;
  localparam int DIV = 4;
  localparam int NV  = 6;
  // {preload, steps, expected count}
  localparam logic [39:0] VEC [NV] = '{
    {16'd10,  8'd3, 16'd7},
    {16'd5,   8'd5, 16'd0},
    {16'd2,   8'd3, 16'hFFFF},
    {16'd0,   8'd1, 16'hFFFF},
    {16'd1,   8'd3, 16'hFFFE},
    {16'd100, 8'd0, 16'd100}
  };

  logic clk = 0, rstN = 0;
  logic cfgWrEn = 0, cfgEnable = 0, cfgIrqEn = 0;
  logic loadWrEn = 0, stsWrEn = 0, stsWrData = 0;
  logic [15:0] loadValue = '0;
  logic [15:0] count;
  logic status, irq;
  int checks = 0, errors = 0;

  gptTimer #(.CNT_W(16), .TICK_DIV(DIV)) dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgEnable(cfgEnable),
    .cfgIrqEn(cfgIrqEn), .loadWrEn(loadWrEn), .loadValue(loadValue),
    .stsWrEn(stsWrEn), .stsWrData(stsWrData), .count(count),
    .status(status), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrCfg(input logic en, input logic ie);
    cfgWrEn = 1; cfgEnable = en; cfgIrqEn = ie;
    edges(1);
    cfgWrEn = 0;
  endtask

  task automatic wrLoad(input logic [15:0] v);
    loadWrEn = 1; loadValue = v;
    edges(1);
    loadWrEn = 0;
  endtask

  task automatic wrSts(input logic d);
    stsWrEn = 1; stsWrData = d;
    edges(1);
    stsWrEn = 0; stsWrData = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    edges(2);
    rstN = 1;
    edges(1);
    chk("R1 count", 32'(count), 32'hFFFF);
    chk("R1 status", 32'(status), 0);
    chk("R1 irq", 32'(irq), 0);

    // vector table: R2/R3/R7/R8
    for (int i = 0; i < NV; i++) begin
      logic [15:0] p, e;
      logic [7:0] k;
      {p, k, e} = VEC[i];
      wrLoad(p);
      wrCfg(1, 1);
      chk("R2 load on enable", 32'(count), 32'(p));
      edges(int'(k) * DIV);
      chk("R3/R7 count after steps", 32'(count), 32'(e));
      chk("R8 status after steps", 32'(status), 32'(k > p));
      wrSts(1);
      wrCfg(0, 0);
      chk("R4 disable to max", 32'(count), 32'hFFFF);
    end

    // R4: hold while disabled
    edges(3 * DIV);
    chk("R4 hold disabled", 32'(count), 32'hFFFF);

    // R5: preload while disabled
    wrLoad(16'd20);
    chk("R5 count unchanged", 32'(count), 32'hFFFF);
    wrCfg(1, 0);
    chk("R5 stored preload used", 32'(count), 20);

    // R6: preload while running
    edges(DIV);
    chk("R6 pre-write step", 32'(count), 19);
    edges(2);
    wrLoad(16'd8);
    chk("R6 immediate reload", 32'(count), 8);
    edges(DIV - 1);
    chk("R6 prescaler restarted", 32'(count), 8);
    edges(1);
    chk("R6 first step after reload", 32'(count), 7);
    wrCfg(0, 0);

    // R8: masked wrap
    wrLoad(16'd0);
    wrCfg(1, 0);
    edges(DIV);
    chk("R7 wrap to max", 32'(count), 32'hFFFF);
    chk("R8 masked no status", 32'(status), 0);
    chk("R8 masked no irq", 32'(irq), 0);
    wrCfg(0, 0);

    // R11 and R9
    wrCfg(1, 1);
    edges(DIV);
    chk("R8 status set", 32'(status), 1);
    chk("R11 irq lags", 32'(irq), 0);
    edges(1);
    chk("R11 irq follows", 32'(irq), 1);
    wrSts(0);
    chk("R9 write 0 no effect", 32'(status), 1);
    wrSts(1);
    chk("R9 write 1 clears", 32'(status), 0);
    edges(1);
    chk("R11 irq drops", 32'(irq), 0);
    wrCfg(0, 0);

    // R10: clear collides with wrap
    wrLoad(16'd0);
    wrCfg(1, 1);
    edges(DIV - 1);
    stsWrEn = 1; stsWrData = 1;
    edges(1);
    stsWrEn = 0; stsWrData = 0;
    chk("R7 wrap at collision", 32'(count), 32'hFFFF);
    chk("R10 set wins", 32'(status), 1);
    wrCfg(0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule